// File: doc/BRIEF.md
# Alarm and Clock-Out Interrupt Logic

This block sits beside the time-of-day counters of a real-time clock. It keeps three write-only alarm latches for seconds, minutes and hours. When the alarm is enabled and all three latches equal the live counters, it raises a latched alarm interrupt. It also builds a square-wave clock output whose period is picked by a four-bit selection code. Short periods come straight from prescaler taps. The minute, hour and day periods are derived from the BCD counter values, so the phase of the wave always follows the current time.

Each falling edge of that internal square wave raises a latched clock interrupt. The two interrupt sources show in the top two bits of a status byte and pull an active-low interrupt line. Reset clears the status, and so does any write to the control register. In power-down the clock output pin is forced low and the interrupt line floats until a source fires. The line then becomes a wake-up signal.

Top module: `rtc_alarm_irq`

## Requirements
- R1: With `pwr_dn` low, selection code 0 holds `clk_out` high. Codes 1 to 12 drive `clk_out` from `sub_tap[code-1]`.
- R2: With `pwr_dn` low, code 13 gives `clk_out` high exactly when the seconds tens digit (`sec_cnt[7:4]`) is 3 or more. Code 14 does the same using the minutes tens digit. Code 15 gives `clk_out` equal to the AM/PM bit `hr_cnt[7]` (1 = PM).
- R3: A high-to-low change of the internal square wave sets status bit 6 at the next clock edge, and `int_n` then reads 0. This holds only while the selection code is nonzero and matches the code of the previous cycle. A change of selection code raises nothing.
- R4: With `alm_en` high, status bit 7 is set at the next edge when all of the following hold:
  - the seconds latch equals `sec_cnt`;
  - the minutes latch equals `min_cnt`;
  - hours bits 5:0 match;
  - in 12-hour mode (`hr_cnt[6]`=1) only, hours bit 7 (AM/PM) also matches.
- R5: The alarm bit is set only on a cycle where the enabled match turns from false to true. A match that persists after a clear does not set it again, and a match with `alm_en` low has no effect.
- R6: Bits 5:0 of `status` always read 0.
- R7: Status bits stay set until a `ctl_wr` pulse or reset. A `ctl_wr` pulse clears both bits, and the clear wins over a set at the same edge.
- R8: Reset clears the status and leaves `int_n` high. It also loads the seconds and minutes alarm latches with 0 and the hours latch with 8'h30, so the counter value 00:00:00 does not match.
- R9: With `pwr_dn` high, `clk_out` is 0. `int_oe` is 0 until a status bit is set and 1 afterwards, with `int_n` low. Alarm matches and internal square-wave falls still set status bits.
- R10: `alm_we` writes `alm_wdata` into the latch selected by `alm_addr`: 0 is seconds, 1 is minutes, 2 is hours (bit 6 ignored), and 3 writes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pwr_dn | input | 1 | Power-down mode, active high |
| ctl_wr | input | 1 | One-cycle pulse marking a control-register write |
| clk_sel | input | 4 | Clock-output selection code |
| alm_en | input | 1 | Alarm enable from the control register |
| alm_we | input | 1 | Alarm latch write strobe |
| alm_addr | input | 2 | Alarm latch select (0 sec, 1 min, 2 hr) |
| alm_wdata | input | 8 | BCD data for the alarm latch |
| sec_cnt | input | 8 | Live seconds counter, BCD |
| min_cnt | input | 8 | Live minutes counter, BCD |
| hr_cnt | input | 8 | Live hours counter: bit 7 PM, bit 6 12-hour mode, bits 5:0 BCD |
| sub_tap | input | 12 | Prescaler square-wave taps for codes 1 to 12 |
| clk_out | output | 1 | Clock output level |
| int_n | output | 1 | Interrupt level, active low |
| int_oe | output | 1 | Interrupt output enable |
| status | output | 8 | Interrupt source: bit 7 alarm, bit 6 clock, rest zero |

## Verification
A stale previous-wave or previous-selection register shows on `status` bit 6 and `int_n` one edge after the input change. It appears either as a spurious source after a selection change or as a missing source after a real fall. A wrong alarm latch or comparison stays invisible until the counters reach the compared value. It then shows as bit 7 arriving, or failing to arrive, one edge later. For this reason the bench steers the counters across each match boundary instead of waiting for them.

// File: rtl/rtc_alarm_irq.sv
module rtc_alarm_irq #(
  parameter int         TAPS   = 12,
  parameter logic [7:0] HR_RST = 8'h30
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pwr_dn,
  input  logic            ctl_wr,
  input  logic [3:0]      clk_sel,
  input  logic            alm_en,
  input  logic            alm_we,
  input  logic [1:0]      alm_addr,
  input  logic [7:0]      alm_wdata,
  input  logic [7:0]      sec_cnt,
  input  logic [7:0]      min_cnt,
  input  logic [7:0]      hr_cnt,
  input  logic [TAPS-1:0] sub_tap,
  output logic            clk_out,
  output logic            int_n,
  output logic            int_oe,
  output logic [7:0]      status
);
  localparam logic [3:0] SEL_MIN  = 4'(TAPS + 1);
  localparam logic [3:0] SEL_HOUR = 4'(TAPS + 2);
  localparam logic [6:0] HR_INIT  = {HR_RST[7], HR_RST[5:0]};

  logic [7:0] al_sec, al_min;
  logic [6:0] al_hr;
  logic [3:0] sel_q;
  logic       sq, sq_q, hit, hit_q, st_alm, st_clk;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      al_sec <= '0;
      al_min <= '0;
      al_hr  <= HR_INIT;
    end else if (alm_we) begin
      case (alm_addr)
        2'd0:    al_sec <= alm_wdata;
        2'd1:    al_min <= alm_wdata;
        2'd2:    al_hr  <= {alm_wdata[7], alm_wdata[5:0]};
        default: ;
      endcase
    end

  always_comb begin
    sq = 1'b1;
    if (clk_sel == SEL_MIN)        sq = sec_cnt[7:4] >= 4'd3;
    else if (clk_sel == SEL_HOUR)  sq = min_cnt[7:4] >= 4'd3;
    else if (clk_sel > SEL_HOUR)   sq = hr_cnt[7];
    else
      for (int i = 0; i < TAPS; i++)
        if (clk_sel == 4'(i + 1)) sq = sub_tap[i];
  end

  assign hit = alm_en && sec_cnt == al_sec && min_cnt == al_min &&
               hr_cnt[5:0] == al_hr[5:0] && (!hr_cnt[6] || hr_cnt[7] == al_hr[6]);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sq_q   <= 1'b1;
      sel_q  <= '0;
      hit_q  <= 1'b0;
      st_alm <= 1'b0;
      st_clk <= 1'b0;
    end else begin
      sq_q  <= sq;
      sel_q <= clk_sel;
      hit_q <= hit;
      if (ctl_wr) begin
        st_alm <= 1'b0;
        st_clk <= 1'b0;
      end else begin
        st_alm <= st_alm | (hit & ~hit_q);
        st_clk <= st_clk | (sq_q & ~sq & (clk_sel != 4'd0) & (clk_sel == sel_q));
      end
    end

  assign clk_out = ~pwr_dn & sq;
  assign int_n   = ~(st_alm | st_clk);
  assign int_oe  = ~pwr_dn | st_alm | st_clk;
  assign status  = {st_alm, st_clk, 6'b0};
endmodule

// File: rtl/rtc_alarm_irq_chk.sv
module rtc_alarm_irq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       pwr_dn,
  input logic       ctl_wr,
  input logic [3:0] clk_sel,
  input logic       clk_out,
  input logic       int_n,
  input logic       int_oe,
  input logic [7:0] status
);
  assert_low_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    status[5:0] == 6'd0);
  assert_idle_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!pwr_dn && clk_sel == 4'd0) |-> clk_out);
  assert_int_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (status[7] || status[6]) |-> !int_n);
  assert_ctl_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr |=> status[7:6] == 2'b00);
  assert_alm_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status[7]) |-> $past(ctl_wr));
  assert_clk_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status[6]) |-> $past(ctl_wr));
  assert_pd_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_dn |-> !clk_out);
  assert_pd_float_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_dn && status[7:6] == 2'b00) |-> !int_oe);
  assert_drive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_dn |-> int_oe);
endmodule

bind rtc_alarm_irq rtc_alarm_irq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pwr_dn(pwr_dn), .ctl_wr(ctl_wr), .clk_sel(clk_sel),
  .clk_out(clk_out), .int_n(int_n), .int_oe(int_oe), .status(status)
);

// File: tb/sim_rtc_alarm_irq.sv
module sim_rtc_alarm_irq;
  localparam int PERIOD = 10;
  localparam int NV = 13;
  // {clk_sel, sec, min, hr, sub_tap, pwr_dn, expected clk_out}
  localparam logic [41:0] VEC [NV] = '{
    {4'd0,  8'h00, 8'h00, 8'h00, 12'h000, 1'b0, 1'b1},  // R1 idle high
    {4'd1,  8'h00, 8'h00, 8'h00, 12'h001, 1'b0, 1'b1},  // R1 tap 0 high
    {4'd1,  8'h00, 8'h00, 8'h00, 12'hFFE, 1'b0, 1'b0},  // R1 tap 0 low
    {4'd12, 8'h00, 8'h00, 8'h00, 12'h800, 1'b0, 1'b1},  // R1 top tap
    {4'd11, 8'h00, 8'h00, 8'h00, 12'h800, 1'b0, 1'b0},  // R1 neighbour tap
    {4'd13, 8'h29, 8'h00, 8'h00, 12'hFFF, 1'b0, 1'b0},  // R2 minute, 29 s
    {4'd13, 8'h30, 8'h00, 8'h00, 12'h000, 1'b0, 1'b1},  // R2 minute, 30 s
    {4'd14, 8'h59, 8'h04, 8'h00, 12'hFFF, 1'b0, 1'b0},  // R2 hour, 4 min
    {4'd14, 8'h00, 8'h45, 8'h00, 12'h000, 1'b0, 1'b1},  // R2 hour, 45 min
    {4'd15, 8'h00, 8'h00, 8'h91, 12'h000, 1'b0, 1'b1},  // R2 day, PM
    {4'd15, 8'h59, 8'h59, 8'h11, 12'hFFF, 1'b0, 1'b0},  // R2 day, AM
    {4'd0,  8'h00, 8'h00, 8'h00, 12'h000, 1'b1, 1'b0},  // R9 idle in pd
    {4'd13, 8'h45, 8'h00, 8'h00, 12'hFFF, 1'b1, 1'b0}   // R9 high wave in pd
  };

  logic clk = 1'b0, rst_n = 1'b0, pwr_dn = 1'b0, ctl_wr = 1'b0, alm_en = 1'b0, alm_we = 1'b0;
  logic [3:0] clk_sel = '0;
  logic [1:0] alm_addr = '0;
  logic [7:0] alm_wdata = '0, sec_cnt = '0, min_cnt = '0, hr_cnt = '0;
  logic [11:0] sub_tap = '0;
  logic clk_out, int_n, int_oe;
  logic [7:0] status;
  int total = 0, fails = 0;
  bit done = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  rtc_alarm_irq u0 (.*);

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_st(input logic [7:0] exp, input string tag);
    chk(status == exp, tag, 32'(status), 32'(exp));
  endtask

  task automatic ctl(input logic [3:0] sel);
    @(negedge clk); clk_sel = sel; ctl_wr = 1'b1;
    @(negedge clk); ctl_wr = 1'b0;
  endtask

  task automatic wr_alm(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); alm_addr = a; alm_wdata = d; alm_we = 1'b1;
    @(negedge clk); alm_we = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk_st(8'h00, "R8 status in reset");
    chk(int_n == 1'b1, "R8 int_n in reset", 32'(int_n), 1);
    chk(int_oe == 1'b1, "R8 int_oe in reset", 32'(int_oe), 1);
    rst_n = 1'b1; alm_en = 1'b1;
    @(negedge clk);
    chk_st(8'h00, "R8 no match at 00:00:00");
    hr_cnt = 8'h30;
    @(negedge clk);
    chk_st(8'h80, "R8 hours latch holds 30");
    alm_en = 1'b0; hr_cnt = 8'h00;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {clk_sel, sec_cnt, min_cnt, hr_cnt, sub_tap, pwr_dn} = VEC[i][41:1];
      #1 chk(clk_out == VEC[i][0], $sformatf("R1 R2 R9 vector %0d", i), 32'(clk_out), 32'(VEC[i][0]));
    end
    @(negedge clk);
    pwr_dn = 1'b0; sec_cnt = '0; min_cnt = 8'h45; hr_cnt = '0; sub_tap = '0;
    ctl(4'd14);
    chk_st(8'h00, "R7 cleared by control write");

    @(negedge clk); min_cnt = 8'h10;
    @(negedge clk);
    chk_st(8'h40, "R3 hour wave falls");
    chk(int_n == 1'b0, "R3 int_n low", 32'(int_n), 0);
    chk(status[5:0] == 6'd0, "R6 low bits zero", 32'(status[5:0]), 0);
    min_cnt = 8'h45;
    repeat (3) @(negedge clk);
    chk_st(8'h40, "R7 clock bit held");
    ctl(4'd14);
    chk_st(8'h00, "R7 clear");
    @(negedge clk); min_cnt = 8'h10; ctl_wr = 1'b1;
    @(negedge clk); ctl_wr = 1'b0;
    chk_st(8'h00, "R7 clear beats set");
    @(negedge clk);
    chk_st(8'h00, "R7 no late set");
    @(negedge clk); sec_cnt = 8'h10; min_cnt = 8'h45;
    ctl(4'd13);
    @(negedge clk);
    chk_st(8'h00, "R3 selection change raises nothing");
    sub_tap = 12'h001;
    ctl(4'd1);
    @(negedge clk); sub_tap = 12'h000;
    @(negedge clk);
    chk_st(8'h40, "R3 tap wave falls");
    ctl(4'd0);

    sec_cnt = 8'h15; min_cnt = 8'h20; hr_cnt = 8'h07;
    wr_alm(2'd0, 8'h15);
    wr_alm(2'd1, 8'h20);
    wr_alm(2'd3, 8'h99);
    wr_alm(2'd2, 8'hC7);
    @(negedge clk);
    chk_st(8'h00, "R5 disabled alarm ignored");
    alm_en = 1'b1;
    @(negedge clk);
    chk_st(8'h80, "R4 24-hour match ignores bit 7");
    chk(int_n == 1'b0, "R4 int_n low", 32'(int_n), 0);
    chk(status[5:0] == 6'd0, "R6 low bits zero on alarm", 32'(status[5:0]), 0);
    ctl(4'd0);
    repeat (2) @(negedge clk);
    chk_st(8'h00, "R5 persisting match not re-set");
    sec_cnt = 8'h16;
    @(negedge clk); sec_cnt = 8'h15;
    @(negedge clk);
    chk_st(8'h80, "R5 new match sets again");
    ctl(4'd0);
    hr_cnt = 8'h47;
    @(negedge clk);
    chk_st(8'h00, "R4 12-hour AM vs PM latch");
    hr_cnt = 8'hC7;
    @(negedge clk);
    chk_st(8'h80, "R4 12-hour PM match");
    ctl(4'd0);
    sec_cnt = 8'h00;
    wr_alm(2'd3, 8'h00);
    sec_cnt = 8'h15;
    @(negedge clk);
    chk_st(8'h80, "R10 address 3 writes nothing");
    ctl(4'd0);

    sec_cnt = 8'h00;
    @(negedge clk); pwr_dn = 1'b1;
    #1 chk(int_oe == 1'b0, "R9 interrupt floats", 32'(int_oe), 0);
    chk(clk_out == 1'b0, "R9 clk_out low", 32'(clk_out), 0);
    @(negedge clk); sec_cnt = 8'h15;
    @(negedge clk);
    chk_st(8'h80, "R9 alarm in power-down");
    chk(int_oe == 1'b1 && int_n == 1'b0, "R9 wake drive", 32'({int_oe, int_n}), 32'h2);
    alm_en = 1'b0; sec_cnt = 8'h45;
    ctl(4'd13);
    chk(int_oe == 1'b0, "R9 float after clear", 32'(int_oe), 0);
    @(negedge clk); sec_cnt = 8'h10;
    @(negedge clk);
    chk_st(8'h40, "R9 internal fall in power-down");
    chk(int_oe == 1'b1 && clk_out == 1'b0, "R9 pin low, int driven", 32'({int_oe, clk_out}), 32'h2);

    @(negedge clk); rst_n = 1'b0;
    #1 chk_st(8'h00, "R8 reset clears status");
    chk(int_n == 1'b1, "R8 int_n released", 32'(int_n), 1);

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule